// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sync-Character Strip

This block turns a single serial input line into bytes. An external rate generator supplies a one-cycle bit strobe. On each strobe the receiver samples the line, which first passes through a two-flop synchronizer. A frame is one low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one stop bit. When a programmed compare value is enabled, characters equal to that value are dropped before they reach the holding register.

A received character waits in a one-entry holding register. It leaves through a valid/ready output: `rx_valid` stays high and `rx_data` stays unchanged until the consumer raises `rx_ready`. The transfer happens on the clock edge where both are high. A character that completes while the register is still occupied is lost and recorded as an overrun, so back-pressure at this output never stalls the line.

Line errors do not appear in the status byte at once. They collect in a hidden staging register and move into the visible status on the transfer that consumes a character. The same transfer raises the error interrupt pulse. When error interrupts are disabled, it raises the buffer-full interrupt pulse instead.

Top module: `serial_rx_strip`

## Requirements
- R1: After reset, `status` reads 0x00, `rx_valid` is low and both interrupt pulses are low.
- R2: Status bit 2 (character in progress) rises after a strobe that samples the line low while idle. It stays high through the data bits and falls after the strobe that samples the last data bit.
- R3: Data bits arrive least significant first. `word_len` 0, 1, 2, 3 selects 8, 7, 6, 5 bits. Shorter characters are delivered right-aligned, with the unused upper bits zero.
- R4: With `par_en` high, a parity bit follows the data. With `par_even` high, the bit must equal the XOR of the data bits; with it low, the bit must equal the complement of that XOR. A mismatch stages a parity error, status bit 5.
- R5: A character that ends with a high stop bit is stored. `rx_valid` and status bit 7 rise, and `irq_full` pulses for one cycle if `ie_full` is high. `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high consumes the character, and that transfer clears status bit 7.
- R6: A character that completes while the holding register is full and not being consumed is discarded. It stages an overrun, status bit 6, and the held data does not change.
- R7: With status bit 1 (strip) set, a character equal to `sync_char` is discarded: there is no `rx_valid` and no `irq_full`.
- R8: A low stop bit with non-zero data stages a frame error, status bit 4. A low stop bit with all-zero data stages no frame error; the break flag, status bit 3, stays staged.
- R9: Staged error bits 6:3 appear in `status` only on the transfer that consumes a character. That transfer then clears the staging register.
- R10: On a transfer whose published bits 6:3 are not all zero, `irq_err` pulses if `ie_err` is high. Otherwise `irq_full` pulses if `ie_full` is high. A transfer with no errors raises no pulse.
- R11: A `stat_wr` with `stat_wdata[0]` low clears all status, empties the holding register and aborts any frame. While bit 0 is low, the line is ignored. A write with bit 0 high loads status bits 0, 1 and 3 from `stat_wdata` and clears the other stored bits.
- R12: The break flag is staged at every start bit. It is dropped when the line is sampled high during the data or stop bits of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idles high |
| bit_en | input | 1 | One-cycle bit strobe from the rate generator |
| word_len | input | 2 | Word length select: 0=8, 1=7, 2=6, 3=5 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even (1) or odd (0) parity |
| sync_char | input | DATA_W | Compare value for the strip function |
| ie_full | input | 1 | Enable for buffer-full interrupt |
| ie_err | input | 1 | Enable for error interrupt |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data |
| status | output | 8 | {full, overrun, parity, frame, break, in-progress, strip, enable} |
| rx_data | output | DATA_W | Holding register contents |
| rx_valid | output | 1 | Holding register occupied |
| rx_ready | input | 1 | Consumer accepts the held character |
| irq_full | output | 1 | Buffer-full interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The break flag is the hardest state to publish. Every start bit stages it and any high data or stop sample drops it. A later clean frame therefore clears it before a read can show it. The stimulus first leaves an earlier character in the holding register and holds back the consumer. It then sends an all-zero frame with a low stop bit and only then consumes the waiting character. A contrasting run sends an all-zero frame with a high stop bit, which the strip compare discards. That frame shows the flag being dropped without causing an overrun.

// File: rtl/rx_strip_pkg.sv
package rx_strip_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_DATA = 2'd1,
    FR_PAR  = 2'd2,
    FR_STOP = 2'd3
  } frame_state_t;

  // per-cycle events from the framer to the status logic
  typedef struct packed {
    logic start;    // start bit accepted
    logic high;     // line seen high inside a frame
    logic par_err;  // parity mismatch
    logic frame;    // low stop with non-zero data
    logic chr;      // character to be stored (not stripped)
  } rx_event_t;

  // status byte bit positions
  localparam int SB_EN    = 0;
  localparam int SB_STRIP = 1;
  localparam int SB_CIP   = 2;
  localparam int SB_BRK   = 3;
  localparam int SB_FRM   = 4;
  localparam int SB_PAR   = 5;
  localparam int SB_OVR   = 6;
  localparam int SB_FULL  = 7;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_strip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic              bit_en,
  input  logic              line,
  input  logic [SEL_W-1:0]  word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              strip,
  input  logic [DATA_W-1:0] sync_char,
  output rx_event_t         ev,
  output logic [DATA_W-1:0] char_data,
  output logic              cip
);
  localparam int CW = $clog2(DATA_W + 1);

  frame_state_t      state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     wlen;
  logic              last_bit;
  logic              take;
  logic              par_exp;
  logic              is_sync;

  assign wlen      = CW'(DATA_W) - CW'(word_len);
  assign last_bit  = (cnt == wlen - CW'(1));
  assign char_data = sh >> word_len;
  assign par_exp   = (^char_data) ^ ~par_even;
  assign is_sync   = strip && (char_data == sync_char);
  assign take      = bit_en && enable && !clr;
  assign cip       = (state == FR_DATA);

  always_comb begin
    ev         = '0;
    ev.start   = take && (state == FR_IDLE) && !line;
    ev.high    = take && ((state == FR_DATA) || (state == FR_STOP)) && line;
    ev.par_err = take && (state == FR_PAR) && (line != par_exp);
    ev.frame   = take && (state == FR_STOP) && !line && (char_data != '0);
    ev.chr     = take && (state == FR_STOP) && line && !is_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      cnt   <= '0;
      sh    <= '0;
    end else if (clr || !enable) begin
      state <= FR_IDLE;
      cnt   <= '0;
    end else if (bit_en) begin
      unique case (state)
        FR_IDLE: if (!line) begin
          state <= FR_DATA;
          cnt   <= '0;
          sh    <= '0;
        end
        FR_DATA: begin
          sh  <= {line, sh[DATA_W-1:1]};
          cnt <= cnt + CW'(1);
          if (last_bit) state <= par_en ? FR_PAR : FR_STOP;
        end
        FR_PAR:  state <= FR_STOP;
        FR_STOP: state <= FR_IDLE;
        default: state <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status
  import rx_strip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_event_t         ev,
  input  logic [DATA_W-1:0] char_data,
  input  logic              cip,
  input  logic              rx_ready,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              ie_full,
  input  logic              ie_err,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              irq_full,
  output logic              irq_err,
  output logic              en,
  output logic              strip
);
  // visible error bits and staged error bits, order {ovr, par, frm, brk}
  logic [3:0]        vis_err;
  logic [3:0]        stg;
  logic [3:0]        stg_nxt;
  logic              full;
  logic [DATA_W-1:0] data_q;
  logic              rd;
  logic              store;
  logic              stg_any;
  logic              irq_full_d;
  logic              irq_err_d;

  assign rd      = full && rx_ready;
  assign store   = ev.chr && !(full && !rd) && !stat_wr;
  assign stg_any = |stg;

  assign irq_err_d  = rd && !stat_wr && stg_any && ie_err;
  assign irq_full_d = (store && ie_full) ||
                      (rd && !stat_wr && stg_any && !ie_err && ie_full);

  always_comb begin
    stg_nxt    = rd ? 4'b0000 : stg;
    stg_nxt[0] = (stg_nxt[0] | ev.start) & ~ev.high;
    stg_nxt[1] = stg_nxt[1] | ev.frame;
    stg_nxt[2] = stg_nxt[2] | ev.par_err;
    stg_nxt[3] = stg_nxt[3] | (ev.chr && full && !rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= stg_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      strip    <= 1'b0;
      vis_err  <= '0;
      full     <= 1'b0;
      data_q   <= '0;
      irq_full <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_full <= irq_full_d;
      irq_err  <= irq_err_d;
      if (stat_wr) begin
        full    <= 1'b0;
        en      <= stat_wdata[SB_EN];
        strip   <= stat_wdata[SB_EN] & stat_wdata[SB_STRIP];
        vis_err <= {3'b000, stat_wdata[SB_EN] & stat_wdata[SB_BRK]};
      end else begin
        if (rd) begin
          full    <= 1'b0;
          vis_err <= stg;
        end
        if (store) begin
          full   <= 1'b1;
          data_q <= char_data;
        end
      end
    end
  end

  assign rx_valid = full;
  assign rx_data  = data_q;
  assign status   = {full, vis_err[3], vis_err[2], vis_err[1], vis_err[0],
                     cip, strip, en};
endmodule

// File: rtl/serial_rx_strip.sv
module serial_rx_strip
  import rx_strip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_en,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              ie_full,
  input  logic              ie_err,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq_full,
  output logic              irq_err
);
  logic              line_s;
  logic              en;
  logic              strip;
  logic              cip;
  logic              clr;
  rx_event_t         ev;
  logic [DATA_W-1:0] char_data;

  assign clr = stat_wr && !stat_wdata[SB_EN];

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  rx_framer #(.DATA_W(DATA_W), .SEL_W(2)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .enable   (en),
    .bit_en   (bit_en),
    .line     (line_s),
    .word_len (word_len),
    .par_en   (par_en),
    .par_even (par_even),
    .strip    (strip),
    .sync_char(sync_char),
    .ev       (ev),
    .char_data(char_data),
    .cip      (cip)
  );

  rx_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .char_data (char_data),
    .cip       (cip),
    .rx_ready  (rx_ready),
    .stat_wr   (stat_wr),
    .stat_wdata(stat_wdata),
    .ie_full   (ie_full),
    .ie_err    (ie_err),
    .status    (status),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .irq_full  (irq_full),
    .irq_err   (irq_err),
    .en        (en),
    .strip     (strip)
  );
endmodule

// File: rtl/serial_rx_strip_chk.sv
module serial_rx_strip_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              rx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              stat_wr,
  input logic [7:0]        stat_wdata,
  input logic [7:0]        status,
  input logic              irq_full,
  input logic              irq_err
);
  // R5: held character stays valid and unchanged without ready
  assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !stat_wr) |=> rx_valid);
  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !stat_wr) |=> $stable(rx_data));
  // R11: disabling write clears everything
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdata[0]) |=> (status == 8'h00 && !rx_valid));
  // R10: error pulse only follows a transfer
  assert_err_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(rx_valid && rx_ready));
  // R5: full pulse only follows a strobe or a transfer
  assert_full_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> $past(bit_en || (rx_valid && rx_ready)));
  // R2: in-progress rises only after a strobe
  assert_cip_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(bit_en));
endmodule

bind serial_rx_strip serial_rx_strip_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .rx_ready  (rx_ready),
  .rx_valid  (rx_valid),
  .rx_data   (rx_data),
  .stat_wr   (stat_wr),
  .stat_wdata(stat_wdata),
  .status    (status),
  .irq_full  (irq_full),
  .irq_err   (irq_err)
);

// File: tb/sim_serial_rx_strip.sv
module sim_serial_rx_strip;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       bit_en = 1'b0;
  logic [1:0] word_len = 2'd0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b1;
  logic [7:0] sync_char = 8'h00;
  logic       ie_full = 1'b1;
  logic       ie_err = 1'b1;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] status;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       irq_full;
  logic       irq_err;

  int checks = 0;
  int errors = 0;
  int n_full = 0;
  int n_err = 0;
  int req_cnt = 0;
  int ack_cnt = 0;
  bit auto_rd = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_strip u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_en(bit_en),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .sync_char(sync_char), .ie_full(ie_full), .ie_err(ie_err),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .status(status),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .irq_full(irq_full), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // interrupt pulse counters
  always @(posedge clk) begin
    if (rst_n) begin
      if (irq_full) n_full++;
      if (irq_err)  n_err++;
    end
  end

  // monitor: drives rx_ready and compares every consumed byte (R3, R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_ready) rx_ready = 1'b0;
      else if (rx_valid && (auto_rd || req_cnt != ack_cnt)) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R3/R5 data", rx_data, e);
        end
        rx_ready = 1'b1;
        if (req_cnt != ack_cnt) ack_cnt++;
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); rx_line = b;
    repeat (3) @(negedge clk);
    bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  // pmode: 0 none, 1 correct parity, 2 wrong parity
  task automatic send_frame(input logic [7:0] d, input int nb, input int pmode,
                            input logic stop, input bit push);
    logic [7:0] m;
    logic p;
    m = d & 8'((1 << nb) - 1);
    if (push) exp_q.push_back(m);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(m[i]);
    if (pmode != 0) begin
      p = (^m) ^ ~par_even;
      if (pmode == 2) p = ~p;
      send_bit(p);
    end
    send_bit(stop);
    @(negedge clk); rx_line = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read();
    req_cnt++;
    wait (ack_cnt == req_cnt);
    @(negedge clk);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    int e0;
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 status", status, 0);
    chk(!rx_valid && !irq_full && !irq_err, "R1 valid/irq", rx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R1 status after release", status, 0);

    wr_stat(8'h01);
    chk(status == 8'h01, "R11 enable write", status, 8'h01);

    // R3 R5: 8-bit stream through the scoreboard
    auto_rd = 1'b1;
    f0 = n_full;
    send_frame(8'hA5, 8, 0, 1'b1, 1'b1);
    send_frame(8'h3C, 8, 0, 1'b1, 1'b1);
    send_frame(8'hFF, 8, 0, 1'b1, 1'b1);
    send_frame(8'h01, 8, 0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk(n_full - f0 == 4, "R5 irq_full count", n_full - f0, 4);

    // R3: shorter words right-aligned
    word_len = 2'd1; send_frame(8'h55, 7, 0, 1'b1, 1'b1);
    word_len = 2'd3; send_frame(8'hF3, 5, 0, 1'b1, 1'b1);
    word_len = 2'd2; send_frame(8'h2A, 6, 0, 1'b1, 1'b1);
    word_len = 2'd0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);

    // R2: in-progress flag
    exp_q.push_back(8'h96);
    send_bit(1'b0);
    chk(status[2] == 1'b1, "R2 cip after start", status[2], 1);
    for (int i = 0; i < 7; i++) send_bit(i[0] ^ i[1] ^ i[2] ? 1'b1 : 1'b0);
    chk(status[2] == 1'b1, "R2 cip before last bit", status[2], 1);
    send_bit(1'b1);
    chk(status[2] == 1'b0, "R2 cip after last bit", status[2], 0);
    send_bit(1'b1);
    repeat (4) @(negedge clk);

    // R4 R9 R10: parity with manual reads
    auto_rd = 1'b0;
    par_en = 1'b1; par_even = 1'b1;
    e0 = n_err;
    send_frame(8'h07, 8, 2, 1'b1, 1'b1);
    chk(status == 8'h81, "R9 error hidden before read", status, 8'h81);
    do_read();
    chk(status == 8'h21, "R4 parity error published", status, 8'h21);
    repeat (2) @(negedge clk);
    chk(n_err - e0 == 1, "R10 irq_err on read", n_err - e0, 1);
    send_frame(8'h07, 8, 1, 1'b1, 1'b1);
    do_read();
    chk(status == 8'h01, "R9 staged cleared / R4 even ok", status, 8'h01);
    par_even = 1'b0;
    send_frame(8'h07, 8, 1, 1'b1, 1'b1);
    do_read();
    chk(status == 8'h01, "R4 odd parity ok", status, 8'h01);

    // R10 fallback to irq_full
    ie_err = 1'b0;
    e0 = n_err; f0 = n_full;
    send_frame(8'h5B, 8, 2, 1'b1, 1'b1);
    do_read();
    repeat (2) @(negedge clk);
    chk(n_err - e0 == 0, "R10 no irq_err when disabled", n_err - e0, 0);
    chk(n_full - f0 == 2, "R10 fallback irq_full", n_full - f0, 2);
    ie_err = 1'b1; par_en = 1'b0; par_even = 1'b1;
    f0 = n_full;
    send_frame(8'h12, 8, 0, 1'b1, 1'b1);
    do_read();
    repeat (2) @(negedge clk);
    chk(n_full - f0 == 1, "R10 clean read no pulse", n_full - f0, 1);

    // R6 overrun
    send_frame(8'h11, 8, 0, 1'b1, 1'b1);
    send_frame(8'h22, 8, 0, 1'b1, 1'b0);
    chk(rx_data == 8'h11, "R6 held data kept", rx_data, 8'h11);
    do_read();
    chk(status == 8'h41, "R6 overrun flag", status, 8'h41);

    // R8 frame error
    send_frame(8'h5A, 8, 0, 1'b0, 1'b0);
    chk(!rx_valid, "R8 no store on low stop", rx_valid, 0);
    send_frame(8'h66, 8, 0, 1'b1, 1'b1);
    do_read();
    chk(status == 8'h11, "R8 frame error", status, 8'h11);

    // R8 break candidate
    send_frame(8'h42, 8, 0, 1'b1, 1'b1);
    send_frame(8'h00, 8, 0, 1'b0, 1'b0);
    do_read();
    chk(status == 8'h09, "R8 break without frame error", status, 8'h09);

    // R7 strip and R12 break drop
    wr_stat(8'h03);
    sync_char = 8'h00;
    send_frame(8'h42, 8, 0, 1'b1, 1'b1);
    f0 = n_full;
    send_frame(8'h00, 8, 0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(n_full == f0, "R7 stripped char no irq", n_full - f0, 0);
    do_read();
    chk(status == 8'h03, "R12 break dropped / R7 no overrun", status, 8'h03);
    sync_char = 8'h7E;
    auto_rd = 1'b1;
    send_frame(8'h7E, 8, 0, 1'b1, 1'b0);
    chk(!rx_valid, "R7 sync char dropped", rx_valid, 0);
    send_frame(8'h7D, 8, 0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 non-sync delivered", exp_q.size(), 0);

    // R11 writes
    auto_rd = 1'b0;
    wr_stat(8'h0F);
    chk(status == 8'h0B, "R11 writable mask", status, 8'h0B);
    wr_stat(8'h01);
    send_frame(8'h44, 8, 0, 1'b1, 1'b0);
    chk(rx_valid, "R5 store visible", rx_valid, 1);
    wr_stat(8'h01);
    chk(!rx_valid && status == 8'h01, "R11 write empties buffer", status, 8'h01);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    wr_stat(8'h00);
    chk(status == 8'h00, "R11 abort mid-frame", status, 0);
    send_frame(8'h33, 8, 0, 1'b1, 1'b0);
    chk(!rx_valid && status == 8'h00, "R11 line ignored when disabled", status, 0);
    wr_stat(8'h01);
    auto_rd = 1'b1;
    send_frame(8'hC3, 8, 0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 receive after re-enable", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule